// File: doc/BRIEF.md
# Flash Program/Erase Controller

This block sits between a 32-bit register bus and a small embedded flash array. Software unlocks it with a fixed two-word key sequence and then picks an operation in the control register. Writing a halfword to the program-data register programs one halfword at the location held in the address register. Setting the start bit together with a page-erase or mass-erase select erases flash. Every operation is checked against a per-page write-protect mask supplied as an input vector. A programming operation is also refused if the target halfword is not erased. The outcome is reported through sticky status flags and a level interrupt.

The array is a behavioural memory whose erased value is 0xFFFF. A fixed busy count, `OP_CYCLES`, models the time an operation takes. A separate array read port returns data after 0, 1 or 2 wait states, as selected by the access-control register.

Three state machines do the work:
- **Key gates.** There are two identical instances, one for the flash lock and one for the option-write enable. Each has the states SHUT, HALF, OPEN and JAMMED.
  - SHUT goes to HALF when the first key is written, and to JAMMED when any other value is written.
  - HALF goes to OPEN when the second key is written, and to JAMMED when any other value is written.
  - OPEN goes back to SHUT on a relock.
  - JAMMED stays in JAMMED until reset.
- **Operation sequencer.** It has the states IDLE, CHECK and WORK.
  - IDLE goes to CHECK when an operation is started.
  - CHECK goes to IDLE with an error flag when a protected page is hit, or when the programming target is not erased. Otherwise it goes to WORK and loads the busy count.
  - WORK counts down, then commits the change to the array, raises the end-of-operation flag and returns to IDLE.

Top module: `flash_ctl`

## Requirements
- R1: After reset the control register (offset 0x10) reads 0x0000_0080 (LOCK, bit 7, set). Status (0x0C), address (0x14) and access control (0x00) read 0, and irq is 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (0x04) clears LOCK. Writing a control word with bit 7 set locks the controller again, and the same two-key sequence unlocks it again.
- R3: Any wrong key value, or the keys in the wrong order, keeps the controller locked until reset. While locked, control writes to PG (bit 0), PER (bit 1), MER (bit 2) and STRT (bit 6) are ignored, and program-data writes start nothing.
- R4: The same two-key sequence written to the option-key register (0x08) sets OPTWRE (control bit 9). A control write with bit 9 at 0 clears it, and a wrong option key keeps OPTWRE at 0 until reset.
- R5: Programming requires the controller to be unlocked, PG to be set and BSY (status bit 0) to be low. A write to the program-data register (0x18) then stores its low halfword at the halfword addressed by the address register (byte address, array base 0x0800_0000). BSY stays high for OP_CYCLES+1 cycles, after which EOP (status bit 5) is set.
- R6: If the target halfword does not read 0xFFFF, PGERR (status bit 2) is set, EOP stays clear, the array is unchanged, and BSY is high for exactly one cycle.
- R7: Programming or page-erasing inside a page whose write-protect bit is set sets WRPRTERR (status bit 4) and leaves the array unchanged. A mass erase is rejected the same way when any protect bit is set.
- R8: A control write with STRT and PER set erases the page holding the address register's location to 0xFFFF and leaves the other pages intact. With MER set, every page is erased, and MER takes precedence over PER. STRT reads 0 once BSY has fallen.
- R9: Writes to the address register are ignored while BSY is high.
- R10: EOP, WRPRTERR and PGERR are each cleared by writing 1 to their bit of the status register. Writing 0 leaves them unchanged.
- R11: irq is high while (EOP and EOPIE, control bit 12) or ((PGERR or WRPRTERR) and ERRIE, control bit 10).
- R12: Access-control bits 2:0 set the wait states W, clamped to 2. A request on rd_req is taken at a clock edge, and rd_valid pulses with the data in the cycle that follows the edge W edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| wp_mask | input | NUM_PAGES | Per-page write protect, 1 = protected |
| rd_req | input | 1 | Array read request |
| rd_idx | input | log2(halfwords) | Halfword index to read |
| rd_data | output | 16 | Array read data |
| rd_valid | output | 1 | Read data valid pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the ones that depend on an operation already being in flight:
- a write to the address register while BSY is high;
- a second program of a halfword that already holds data;
- a mass erase while only one page is protected.

The bench reaches them by programming every halfword of the array in a sweep, and by issuing register writes in the cycle right after a start. It also sweeps the protect mask across every page before the final mass erase. Each read-back goes through the wait-state port with a different latency setting, so data and timing are checked together.

// File: rtl/flash_pkg.sv
package flash_pkg;
    typedef enum logic [1:0] {KEY_SHUT, KEY_HALF, KEY_OPEN, KEY_JAMMED} key_state_t;
    typedef enum logic [1:0] {SQ_IDLE, SQ_CHECK, SQ_WORK} seq_state_t;
    typedef enum logic [1:0] {OP_PROG, OP_PAGE_ERASE, OP_MASS_ERASE} op_kind_t;

    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;
    localparam logic [15:0] HW_ERASED  = 16'hFFFF;

    localparam logic [4:0] OFS_ACC  = 5'h00;
    localparam logic [4:0] OFS_KEY  = 5'h04;
    localparam logic [4:0] OFS_OKEY = 5'h08;
    localparam logic [4:0] OFS_STAT = 5'h0C;
    localparam logic [4:0] OFS_CTRL = 5'h10;
    localparam logic [4:0] OFS_ADDR = 5'h14;
    localparam logic [4:0] OFS_DATA = 5'h18;

    localparam int B_BSY   = 0;
    localparam int B_PGERR = 2;
    localparam int B_WPERR = 4;
    localparam int B_EOP   = 5;

    localparam int B_PG    = 0;
    localparam int B_PER   = 1;
    localparam int B_MER   = 2;
    localparam int B_STRT  = 6;
    localparam int B_LOCK  = 7;
    localparam int B_OPTWE = 9;
    localparam int B_ERRIE = 10;
    localparam int B_EOPIE = 12;
endpackage

// File: rtl/flash_key_gate.sv
module flash_key_gate
    import flash_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_we,
    input  logic [31:0] key_val,
    input  logic        relock,
    output logic        open_o
);
    key_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KEY_SHUT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KEY_SHUT:   if (key_we) st_d = (key_val == KEY_FIRST)  ? KEY_HALF : KEY_JAMMED;
            KEY_HALF:   if (key_we) st_d = (key_val == KEY_SECOND) ? KEY_OPEN : KEY_JAMMED;
            KEY_OPEN:   if (relock) st_d = KEY_SHUT;
            KEY_JAMMED: st_d = KEY_JAMMED;
            default:    st_d = KEY_SHUT;
        endcase
    end

    always_comb open_o = (st_q == KEY_OPEN);

    // R3
    key_jam_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == KEY_JAMMED |=> st_q == KEY_JAMMED);

    // R2
    key_open_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(st_q) == KEY_HALF && $past(key_we));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int NUM_HW      = 32,
    parameter int HW_PER_PAGE = 8,
    parameter int IDX_W       = 5,
    parameter int PAGE_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [15:0]       wr_data,
    input  logic              erase_page_en,
    input  logic [PAGE_W-1:0] erase_page_idx,
    input  logic              erase_all_en,
    input  logic [IDX_W-1:0]  chk_idx,
    output logic [15:0]       chk_data,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [1:0]        wait_sel,
    output logic [15:0]       rd_data,
    output logic              rd_valid
);
    logic [15:0]      mem_q [NUM_HW];
    logic             pend_q;
    logic [1:0]       cnt_q;
    logic [IDX_W-1:0] ridx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_HW; i++) mem_q[i] <= 16'hFFFF;
        end else begin
            for (int i = 0; i < NUM_HW; i++) begin
                if (erase_all_en ||
                    (erase_page_en && (i / HW_PER_PAGE) == int'(erase_page_idx)))
                    mem_q[i] <= 16'hFFFF;
                else if (wr_en && i == int'(wr_idx))
                    mem_q[i] <= wr_data;
            end
        end
    end

    always_comb chk_data = mem_q[chk_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            ridx_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (pend_q) begin
                if (cnt_q == 2'd0) begin
                    rd_valid <= 1'b1;
                    rd_data  <= mem_q[ridx_q];
                    pend_q   <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 2'd1;
                end
            end else if (rd_req) begin
                if (wait_sel == 2'd0) begin
                    rd_valid <= 1'b1;
                    rd_data  <= mem_q[rd_idx];
                end else begin
                    pend_q <= 1'b1;
                    cnt_q  <= wait_sel - 2'd1;
                    ridx_q <= rd_idx;
                end
            end
        end
    end

    // R12
    rd_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !rd_valid);

    // R12
    rd_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !$past(rd_req) |-> $past(pend_q));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_pkg::*;
#(
    parameter int OP_CYCLES = 4,
    parameter int NUM_PAGES = 4,
    parameter int IDX_W     = 5,
    parameter int PAGE_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_prog,
    input  logic                 start_erase,
    input  logic                 erase_mass,
    input  logic [IDX_W-1:0]     tgt_idx,
    input  logic [15:0]          prog_val,
    input  logic [NUM_PAGES-1:0] wp_mask,
    input  logic [15:0]          chk_data,
    output logic [IDX_W-1:0]     chk_idx,
    output logic                 busy,
    output logic                 fin_ok,
    output logic                 fin_pgerr,
    output logic                 fin_wperr,
    output logic                 arr_wr_en,
    output logic [IDX_W-1:0]     arr_wr_idx,
    output logic [15:0]          arr_wr_data,
    output logic                 arr_pg_erase,
    output logic [PAGE_W-1:0]    arr_pg_idx,
    output logic                 arr_mass_erase
);
    localparam int CNT_W = $clog2(OP_CYCLES + 1);
    localparam int OFS_W = IDX_W - PAGE_W;

    seq_state_t       st_q, st_d;
    op_kind_t         kind_q;
    logic [IDX_W-1:0] idx_q;
    logic [15:0]      val_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PAGE_W-1:0] page_of;
    logic             wp_hit;

    always_comb begin
        page_of = idx_q[IDX_W-1:OFS_W];
        wp_hit  = (kind_q == OP_MASS_ERASE) ? (|wp_mask) : wp_mask[page_of];
    end

    // state register and operand latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            kind_q <= OP_PROG;
            idx_q  <= '0;
            val_q  <= '0;
            cnt_q  <= '0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                SQ_IDLE: begin
                    if (start_prog || start_erase) begin
                        idx_q  <= tgt_idx;
                        val_q  <= prog_val;
                        kind_q <= start_erase ? (erase_mass ? OP_MASS_ERASE : OP_PAGE_ERASE)
                                              : OP_PROG;
                    end
                end
                SQ_CHECK: cnt_q <= CNT_W'(OP_CYCLES - 1);
                SQ_WORK:  if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= '0;
            endcase
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:  if (start_prog || start_erase) st_d = SQ_CHECK;
            SQ_CHECK: st_d = (fin_wperr || fin_pgerr) ? SQ_IDLE : SQ_WORK;
            SQ_WORK:  if (fin_ok) st_d = SQ_IDLE;
            default:  st_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy           = (st_q != SQ_IDLE);
        fin_ok         = 1'b0;
        fin_pgerr      = 1'b0;
        fin_wperr      = 1'b0;
        arr_wr_en      = 1'b0;
        arr_pg_erase   = 1'b0;
        arr_mass_erase = 1'b0;
        chk_idx        = idx_q;
        arr_wr_idx     = idx_q;
        arr_wr_data    = val_q;
        arr_pg_idx     = page_of;
        unique case (st_q)
            SQ_IDLE: begin end
            SQ_CHECK: begin
                if (wp_hit) fin_wperr = 1'b1;
                else if (kind_q == OP_PROG && chk_data != HW_ERASED) fin_pgerr = 1'b1;
            end
            SQ_WORK: begin
                if (cnt_q == '0) begin
                    fin_ok         = 1'b1;
                    arr_wr_en      = (kind_q == OP_PROG);
                    arr_pg_erase   = (kind_q == OP_PAGE_ERASE);
                    arr_mass_erase = (kind_q == OP_MASS_ERASE);
                end
            end
            default: begin end
        endcase
    end

    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_prog || start_erase));

    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fin_ok || fin_pgerr || fin_wperr));

    // R7
    fin_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fin_ok, fin_pgerr, fin_wperr}));
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
    import flash_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h0800_0000,
    parameter int          PAGE_BYTES = 16,
    parameter int          NUM_PAGES  = 4,
    parameter int          OP_CYCLES  = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          reg_we,
    input  logic [4:0]                                    reg_addr,
    input  logic [31:0]                                   reg_wdata,
    output logic [31:0]                                   reg_rdata,
    input  logic [NUM_PAGES-1:0]                          wp_mask,
    input  logic                                          rd_req,
    input  logic [$clog2(PAGE_BYTES/2*NUM_PAGES)-1:0]     rd_idx,
    output logic [15:0]                                   rd_data,
    output logic                                          rd_valid,
    output logic                                          irq
);
    localparam int HW_PER_PAGE = PAGE_BYTES / 2;
    localparam int NUM_HW      = HW_PER_PAGE * NUM_PAGES;
    localparam int IDX_W       = $clog2(NUM_HW);
    localparam int PAGE_W      = $clog2(NUM_PAGES);

    logic        flash_open, opt_open;
    logic [2:0]  lat_q;
    logic [1:0]  wait_sel;
    logic        st_eop, st_pgerr, st_wperr;
    logic        cr_pg, cr_per, cr_mer, cr_strt, cr_errie, cr_eopie;
    logic [31:0] ar_q, ar_off;
    logic        wr_acc, wr_key, wr_okey, wr_sta, wr_ctl, wr_adr, wr_dat;
    logic        start_prog, start_erase, ops_ok;
    logic        busy, fin_ok, fin_pgerr, fin_wperr;
    logic [IDX_W-1:0]  tgt_idx, chk_idx, arr_wr_idx;
    logic [15:0]       chk_data, arr_wr_data;
    logic              arr_wr_en, arr_pg_erase, arr_mass_erase;
    logic [PAGE_W-1:0] arr_pg_idx;

    always_comb begin
        wr_acc  = reg_we && reg_addr == OFS_ACC;
        wr_key  = reg_we && reg_addr == OFS_KEY;
        wr_okey = reg_we && reg_addr == OFS_OKEY;
        wr_sta  = reg_we && reg_addr == OFS_STAT;
        wr_ctl  = reg_we && reg_addr == OFS_CTRL;
        wr_adr  = reg_we && reg_addr == OFS_ADDR;
        wr_dat  = reg_we && reg_addr == OFS_DATA;
        ops_ok      = flash_open && !busy;
        start_prog  = wr_dat && ops_ok && cr_pg;
        start_erase = wr_ctl && ops_ok && reg_wdata[B_STRT] &&
                      (reg_wdata[B_PER] || reg_wdata[B_MER]);
        ar_off   = ar_q - BASE_ADDR;
        tgt_idx  = ar_off[IDX_W:1];
        wait_sel = (lat_q > 3'd2) ? 2'd2 : lat_q[1:0];
    end

    flash_key_gate u_main_key (
        .clk(clk), .rst_n(rst_n), .key_we(wr_key), .key_val(reg_wdata),
        .relock(wr_ctl && reg_wdata[B_LOCK]), .open_o(flash_open)
    );

    flash_key_gate u_opt_key (
        .clk(clk), .rst_n(rst_n), .key_we(wr_okey), .key_val(reg_wdata),
        .relock(wr_ctl && !reg_wdata[B_OPTWE]), .open_o(opt_open)
    );

    flash_seq #(
        .OP_CYCLES(OP_CYCLES), .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .PAGE_W(PAGE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_prog(start_prog), .start_erase(start_erase),
        .erase_mass(reg_wdata[B_MER]), .tgt_idx(tgt_idx), .prog_val(reg_wdata[15:0]),
        .wp_mask(wp_mask), .chk_data(chk_data), .chk_idx(chk_idx),
        .busy(busy), .fin_ok(fin_ok), .fin_pgerr(fin_pgerr), .fin_wperr(fin_wperr),
        .arr_wr_en(arr_wr_en), .arr_wr_idx(arr_wr_idx), .arr_wr_data(arr_wr_data),
        .arr_pg_erase(arr_pg_erase), .arr_pg_idx(arr_pg_idx),
        .arr_mass_erase(arr_mass_erase)
    );

    flash_array #(
        .NUM_HW(NUM_HW), .HW_PER_PAGE(HW_PER_PAGE), .IDX_W(IDX_W), .PAGE_W(PAGE_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(arr_wr_en), .wr_idx(arr_wr_idx), .wr_data(arr_wr_data),
        .erase_page_en(arr_pg_erase), .erase_page_idx(arr_pg_idx),
        .erase_all_en(arr_mass_erase),
        .chk_idx(chk_idx), .chk_data(chk_data),
        .rd_req(rd_req), .rd_idx(rd_idx), .wait_sel(wait_sel),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q    <= '0;
            ar_q     <= '0;
            st_eop   <= 1'b0;
            st_pgerr <= 1'b0;
            st_wperr <= 1'b0;
            cr_pg    <= 1'b0;
            cr_per   <= 1'b0;
            cr_mer   <= 1'b0;
            cr_strt  <= 1'b0;
            cr_errie <= 1'b0;
            cr_eopie <= 1'b0;
        end else begin
            if (wr_acc) lat_q <= reg_wdata[2:0];
            if (wr_adr && !busy) ar_q <= reg_wdata;
            if (wr_ctl) begin
                cr_errie <= reg_wdata[B_ERRIE];
                cr_eopie <= reg_wdata[B_EOPIE];
                if (ops_ok) begin
                    cr_pg  <= reg_wdata[B_PG];
                    cr_per <= reg_wdata[B_PER];
                    cr_mer <= reg_wdata[B_MER];
                end
            end
            if (start_erase) cr_strt <= 1'b1;
            else if (fin_ok || fin_pgerr || fin_wperr) cr_strt <= 1'b0;
            if (fin_ok) st_eop <= 1'b1;
            else if (wr_sta && reg_wdata[B_EOP]) st_eop <= 1'b0;
            if (fin_pgerr) st_pgerr <= 1'b1;
            else if (wr_sta && reg_wdata[B_PGERR]) st_pgerr <= 1'b0;
            if (fin_wperr) st_wperr <= 1'b1;
            else if (wr_sta && reg_wdata[B_WPERR]) st_wperr <= 1'b0;
        end
    end

    always_comb begin
        irq = (st_eop && cr_eopie) || ((st_pgerr || st_wperr) && cr_errie);
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_ACC: reg_rdata[2:0] = lat_q;
            OFS_STAT: begin
                reg_rdata[B_BSY]   = busy;
                reg_rdata[B_PGERR] = st_pgerr;
                reg_rdata[B_WPERR] = st_wperr;
                reg_rdata[B_EOP]   = st_eop;
            end
            OFS_CTRL: begin
                reg_rdata[B_PG]    = cr_pg;
                reg_rdata[B_PER]   = cr_per;
                reg_rdata[B_MER]   = cr_mer;
                reg_rdata[B_STRT]  = cr_strt;
                reg_rdata[B_LOCK]  = !flash_open;
                reg_rdata[B_OPTWE] = opt_open;
                reg_rdata[B_ERRIE] = cr_errie;
                reg_rdata[B_EOPIE] = cr_eopie;
            end
            OFS_ADDR: reg_rdata = ar_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R9
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ar_q));

    // R8
    strt_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cr_strt);

    // R3
    locked_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_open |=> !$rose(busy));
endmodule

// File: tb/tb_flash_ctl.sv
module tb_flash_ctl;
    localparam logic [31:0] BASE = 32'h0800_0000;
    localparam int HWPP = 8;
    localparam int NPG  = 4;
    localparam int NHW  = HWPP * NPG;
    localparam int OPC  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NPG-1:0] wp_mask = '0;
    logic        rd_req = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    flash_ctl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wp_mask(wp_mask),
        .rd_req(rd_req), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 16'h0123 + 16'h1000);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // counts the cycles BSY stays high, starting at the negedge after a start
    task automatic busy_cycles(output int n);
        logic [31:0] s;
        n = 0;
        rreg(5'h0C, s);
        while (s[0] && n < 1000) begin
            n++;
            @(negedge clk);
            rreg(5'h0C, s);
        end
    endtask

    task automatic aread(input int idx, output logic [15:0] d, output int lat);
        @(negedge clk);
        rd_req = 1'b1; rd_idx = 5'(idx);
        @(negedge clk);
        rd_req = 1'b0;
        lat = 0;
        while (!rd_valid && lat < 20) begin
            lat++;
            @(negedge clk);
        end
        d = rd_data;
    endtask

    task automatic unlock;
        wr(5'h04, 32'h4567_0123);
        wr(5'h04, 32'hCDEF_89AB);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] v;
        logic [15:0] d;
        int lat;
        int n;

        do_reset();
        // R1 reset state
        rreg(5'h10, v); chk("R1 ctrl", v, 32'h80);
        rreg(5'h0C, v); chk("R1 status", v, 32'h0);
        rreg(5'h14, v); chk("R1 addr", v, 32'h0);
        rreg(5'h00, v); chk("R1 acc", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3 op bits ignored while locked, program write starts nothing
        wr(5'h10, 32'h0000_0047);
        rreg(5'h10, v); chk("R3 locked ctrl", v, 32'h80);
        wr(5'h14, BASE);
        wr(5'h18, 32'h0000_1234);
        rreg(5'h0C, v); chk("R3 locked no busy", v, 32'h0);

        // R2 unlock, relock, unlock
        unlock();
        rreg(5'h10, v); chk("R2 unlocked", v, 32'h0);
        wr(5'h10, 32'h80);
        rreg(5'h10, v); chk("R2 relocked", v, 32'h80);
        unlock();
        rreg(5'h10, v); chk("R2 unlocked again", v, 32'h0);

        // R4 option enable set and clear
        wr(5'h08, 32'h4567_0123);
        wr(5'h08, 32'hCDEF_89AB);
        rreg(5'h10, v); chk("R4 optwre set", {31'b0, v[9]}, 32'h1);
        wr(5'h10, 32'h0);
        rreg(5'h10, v); chk("R4 optwre cleared", {31'b0, v[9]}, 32'h0);

        // R5 program sweep over every halfword
        wr(5'h10, 32'h0000_1401);
        for (int i = 0; i < NHW; i++) begin
            wr(5'h14, BASE + 32'(2 * i));
            wr(5'h18, {16'h0, pat(i)});
            busy_cycles(n);
            if (i == 0) chk("R5 busy length", 32'(n), 32'(OPC + 1));
            rreg(5'h0C, v);
            chk("R5 eop after program", v, 32'h20);
            if (i == 0) chk("R11 irq on eop", {31'b0, irq}, 32'h1);
            if (i == 0) begin
                wr(5'h0C, 32'h0);
                rreg(5'h0C, v); chk("R10 write 0 keeps eop", v, 32'h20);
            end
            wr(5'h0C, 32'h20);
            if (i == 0) begin
                rreg(5'h0C, v); chk("R10 eop cleared", v, 32'h0);
                chk("R11 irq drops", {31'b0, irq}, 32'h0);
            end
        end

        // R12 read back through the wait-state port, latency swept 0..3
        for (int i = 0; i < NHW; i++) begin
            wr(5'h00, 32'(i % 4));
            aread(i, d, lat);
            chk("R5 array data", {16'h0, d}, {16'h0, pat(i)});
            chk("R12 latency", 32'(lat), 32'((i % 4) > 2 ? 2 : (i % 4)));
        end
        wr(5'h00, 32'h0);

        // R6 reprogramming a written halfword
        wr(5'h14, BASE + 32'(2 * 5));
        wr(5'h18, 32'h0);
        busy_cycles(n);
        chk("R6 busy one cycle", 32'(n), 32'h1);
        rreg(5'h0C, v); chk("R6 pgerr only", v, 32'h04);
        chk("R11 irq on error", {31'b0, irq}, 32'h1);
        aread(5, d, lat); chk("R6 array unchanged", {16'h0, d}, {16'h0, pat(5)});
        wr(5'h0C, 32'h04);
        rreg(5'h0C, v); chk("R10 pgerr cleared", v, 32'h0);

        // R8 R9 page erase of page 2 with an address write during busy
        wr(5'h14, BASE + 32'(2 * HWPP * 2 + 6));
        wr(5'h10, 32'h0000_1442);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'h14; reg_wdata = 32'h0000_1234;
        @(negedge clk);
        reg_we = 1'b0;
        busy_cycles(n);
        rreg(5'h14, v); chk("R9 addr held", v, BASE + 32'(2 * HWPP * 2 + 6));
        rreg(5'h10, v); chk("R8 strt cleared", {31'b0, v[6]}, 32'h0);
        rreg(5'h0C, v); chk("R8 eop after erase", v, 32'h20);
        wr(5'h0C, 32'h20);
        for (int i = 0; i < NHW; i++) begin
            aread(i, d, lat);
            chk("R8 page erase contents", {16'h0, d},
                {16'h0, (i / HWPP == 2) ? 16'hFFFF : pat(i)});
        end

        // R7 protected program into erased page 2, with ERRIE off
        wr(5'h10, 32'h0000_1001);
        wp_mask = 4'b0100;
        wr(5'h14, BASE + 32'(2 * 17));
        wr(5'h18, 32'h0000_5555);
        busy_cycles(n);
        rreg(5'h0C, v); chk("R7 wrprterr", v, 32'h10);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        aread(17, d, lat); chk("R7 array kept", {16'h0, d}, 32'hFFFF);
        wr(5'h0C, 32'h10);

        // R7 sweep: page erase of each protected page, mass erase with one bit set
        for (int p = 0; p < NPG; p++) begin
            wp_mask = 4'(1 << p);
            wr(5'h14, BASE + 32'(2 * HWPP * p));
            wr(5'h10, 32'h0000_0042);
            busy_cycles(n);
            rreg(5'h0C, v); chk("R7 page erase protected", v, 32'h10);
            wr(5'h0C, 32'h10);
            wr(5'h10, 32'h0000_0044);
            busy_cycles(n);
            rreg(5'h0C, v); chk("R7 mass erase protected", v, 32'h10);
            wr(5'h0C, 32'h10);
            aread(p * HWPP + 1, d, lat);
            chk("R7 contents kept", {16'h0, d},
                {16'h0, (p == 2) ? 16'hFFFF : pat(p * HWPP + 1)});
        end

        // R8 mass erase, MER wins over PER
        wp_mask = '0;
        wr(5'h10, 32'h0000_0046);
        busy_cycles(n);
        rreg(5'h0C, v); chk("R8 mass eop", v, 32'h20);
        wr(5'h0C, 32'h20);
        for (int i = 0; i < NHW; i += 3) begin
            aread(i, d, lat); chk("R8 mass erased", {16'h0, d}, 32'hFFFF);
        end

        // R3 wrong key order jams the lock
        wr(5'h10, 32'h80);
        wr(5'h04, 32'hCDEF_89AB);
        unlock();
        rreg(5'h10, v); chk("R3 jammed stays locked", {31'b0, v[7]}, 32'h1);
        // R4 wrong option key jams option enable
        wr(5'h08, 32'h1111_2222);
        wr(5'h08, 32'h4567_0123);
        wr(5'h08, 32'hCDEF_89AB);
        rreg(5'h10, v); chk("R4 option jammed", {31'b0, v[9]}, 32'h0);

        // R3 reset releases the jam
        do_reset();
        unlock();
        rreg(5'h10, v); chk("R3 unlock after reset", v, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule